// File: doc/BRIEF.md
# Race-to-Sleep Power Sequencer

This block sequences the power of an application processor that handles light loads by bursting and sleeping. While work is pending the processor runs with its clock enabled and full supply. When the work is reported finished, the block stops the clock first. It then waits a programmable settle window and lowers the supply. When new work arrives, it raises the supply, waits a programmable ramp window and only then re-enables the clock. The processor therefore spends most of its time asleep during steady loads such as audio playback.

A second, independent activity flag tracks the baseband processor. The two flags form a 2-bit joint state with four values. The audio I/O domain has its own clock-enable and power outputs. These are held on in every state, so sound continues while the application processor sleeps. All control pins are plain level or pulse signals with no handshake. A wake request that arrives while the clock is stopped but the supply is still high cancels the sleep entry: the clock comes back without the supply ever dropping.

Top module: `pwr_race_ctrl`

## Requirements
- R1: After reset, `ap_clk_en`=1, `ap_vdd_high`=1 and `pwr_state`=2'b11 (bit 0 = application processor running, bit 1 = baseband active).
- R2: With the processor running, `ap_work_done`=1 and `ap_work_req`=0 sampled at a clock edge clear `ap_clk_en` and `pwr_state[0]` from that edge on, while `ap_vdd_high` stays 1.
- R3: `ap_vdd_high` falls exactly `cfg_settle`+1 cycles after `ap_clk_en` fell, unless the sequence is aborted.
- R4: While asleep, a sampled `ap_work_req` raises `ap_vdd_high` at that edge. `ap_clk_en` and `pwr_state[0]` rise `cfg_ramp`+1 cycles later.
- R5: A sampled `ap_work_req` during the settle window re-enables the clock at that edge and keeps the supply high. This applies even in the window's last cycle.
- R6: `ap_clk_en` is never 1 while `ap_vdd_high` is 0. The clock only turns on after a cycle with the supply high, and the supply only drops after a cycle with the clock off.
- R7: `ap_work_req` and `ap_work_done` during the ramp window have no effect on its timing. `ap_work_req` and `ap_work_done` together while running keep the processor running.
- R8: `bb_wake` sets `pwr_state[1]` one edge later and `bb_sleep` clears it. When both are high, `bb_wake` wins. Baseband changes never alter the application processor's timing.
- R9: `aio_clk_en` and `aio_pwr_on` are 1 in every state, including during reset.
- R10: With `cfg_settle`=0 the supply drops one cycle after the clock. With `cfg_ramp`=0 the clock returns one cycle after the supply.

Parameter `CNT_W` sets the width of the two window counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ap_work_req | input | 1 | Work pending / wake for the application processor |
| ap_work_done | input | 1 | Application processor finished its burst |
| bb_wake | input | 1 | Baseband becomes active |
| bb_sleep | input | 1 | Baseband goes to sleep |
| cfg_settle | input | CNT_W | Settle window before supply reduction |
| cfg_ramp | input | CNT_W | Ramp window before clock restart |
| ap_clk_en | output | 1 | Application processor clock enable |
| ap_vdd_high | output | 1 | Application processor supply at full level |
| aio_clk_en | output | 1 | Audio I/O clock enable |
| aio_pwr_on | output | 1 | Audio I/O power enable |
| pwr_state | output | 2 | Joint state {baseband active, application processor running} |

## Verification
A sequencer stuck in the wrong phase appears at the ports within one cycle as a clock-enable or supply edge that is missing, extra or displaced. The bench timestamps every change of the two supply controls and the state code against cycle numbers derived from the window counts. A window counter that is off by one shifts the supply or clock edge by exactly one cycle. A mishandled abort shows up as a supply drop that should never appear.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    AP_RUN   = 2'd0,
    AP_GATE  = 2'd1,
    AP_SLEEP = 2'd2,
    AP_RAMP  = 2'd3
  } ap_state_e;
endpackage

// File: rtl/pwr_dly_cnt.sv
module pwr_dly_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  assign expired = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ap_seq.sv
module ap_seq
  import pwrseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             work_req,
  input  logic             work_done,
  input  logic [CNT_W-1:0] cfg_settle,
  input  logic [CNT_W-1:0] cfg_ramp,
  output logic             clk_en,
  output logic             vdd_high
);
  ap_state_e        state_q, state_d;
  logic             counting;
  logic             win_done;
  logic [CNT_W-1:0] win_limit;

  assign counting  = (state_q == AP_GATE) || (state_q == AP_RAMP);
  assign win_limit = (state_q == AP_GATE) ? cfg_settle : cfg_ramp;

  pwr_dly_cnt #(.CNT_W(CNT_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!counting),
    .limit   (win_limit),
    .expired (win_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      AP_RUN:   if (work_done && !work_req) state_d = AP_GATE;
      AP_GATE:  if (work_req)               state_d = AP_RUN;
                else if (win_done)          state_d = AP_SLEEP;
      AP_SLEEP: if (work_req)               state_d = AP_RAMP;
      AP_RAMP:  if (win_done)               state_d = AP_RUN;
      default:                              state_d = AP_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= AP_RUN;
    else        state_q <= state_d;
  end

  assign clk_en   = (state_q == AP_RUN);
  assign vdd_high = (state_q != AP_SLEEP);

  // R5: a wake inside the settle window returns straight to running
  assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == AP_GATE && work_req) |=> (state_q == AP_RUN))
    else $error("abort did not restore run");

  // R7: the ramp window is not cut short by request inputs
  assert_ramp_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == AP_RAMP && !win_done) |=> (state_q == AP_RAMP))
    else $error("ramp window left early");
endmodule

// File: rtl/bb_track.sv
module bb_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  input  logic sleep,
  output logic active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     active <= 1'b1;
    else if (wake)  active <= 1'b1;
    else if (sleep) active <= 1'b0;
  end

  // R8: wake has priority and takes effect at the next edge
  assert_bb_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> active)
    else $error("baseband wake lost");
endmodule

// File: rtl/pwr_race_ctrl.sv
module pwr_race_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ap_work_req,
  input  logic             ap_work_done,
  input  logic             bb_wake,
  input  logic             bb_sleep,
  input  logic [CNT_W-1:0] cfg_settle,
  input  logic [CNT_W-1:0] cfg_ramp,
  output logic             ap_clk_en,
  output logic             ap_vdd_high,
  output logic             aio_clk_en,
  output logic             aio_pwr_on,
  output logic [1:0]       pwr_state
);
  logic bb_active;

  ap_seq #(.CNT_W(CNT_W)) u_ap (
    .clk        (clk),
    .rst_n      (rst_n),
    .work_req   (ap_work_req),
    .work_done  (ap_work_done),
    .cfg_settle (cfg_settle),
    .cfg_ramp   (cfg_ramp),
    .clk_en     (ap_clk_en),
    .vdd_high   (ap_vdd_high)
  );

  bb_track u_bb (
    .clk    (clk),
    .rst_n  (rst_n),
    .wake   (bb_wake),
    .sleep  (bb_sleep),
    .active (bb_active)
  );

  assign aio_clk_en = 1'b1;
  assign aio_pwr_on = 1'b1;
  assign pwr_state  = {bb_active, ap_clk_en};

  // R6: clock only with full supply, and in the right order
  assert_clk_needs_vdd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ap_clk_en |-> ap_vdd_high)
    else $error("clock enabled on low supply");
  assert_vdd_before_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ap_clk_en) |-> $past(ap_vdd_high))
    else $error("clock restarted before supply");
  // R3: supply only drops after the clock was already stopped
  assert_clk_off_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ap_vdd_high) |-> !$past(ap_clk_en))
    else $error("supply dropped with clock running");
  // R2: a finished burst stops the clock at the next edge
  assert_done_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_clk_en && ap_work_done && !ap_work_req) |=> !ap_clk_en)
    else $error("clock not gated after done");
endmodule

// File: tb/pwr_race_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_race_ctrl_tb;
  localparam int CNT_W = 8;

  typedef struct {
    int         cyc;
    logic       ce;
    logic       vd;
    logic [1:0] cd;
    string      req;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ap_work_req = 1'b0, ap_work_done = 1'b0, bb_wake = 1'b0, bb_sleep = 1'b0;
  logic [CNT_W-1:0] cfg_settle = 8'd3, cfg_ramp = 8'd4;
  logic ap_clk_en, ap_vdd_high, aio_clk_en, aio_pwr_on;
  logic [1:0] pwr_state;

  int   cyc = 0;
  int   checks = 0, errors = 0;
  bit   mon_en = 1'b0;
  ev_t  expq[$];
  logic [3:0] prev;
  logic eb = 1'b1;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_race_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ap_work_req(ap_work_req), .ap_work_done(ap_work_done),
    .bb_wake(bb_wake), .bb_sleep(bb_sleep), .cfg_settle(cfg_settle), .cfg_ramp(cfg_ramp),
    .ap_clk_en(ap_clk_en), .ap_vdd_high(ap_vdd_high), .aio_clk_en(aio_clk_en),
    .aio_pwr_on(aio_pwr_on), .pwr_state(pwr_state)
  );

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  task automatic push(input int c, input logic ce, input logic vd, input logic [1:0] cd, input string r);
    ev_t e;
    e.cyc = c; e.ce = ce; e.vd = vd; e.cd = cd; e.req = r;
    expq.push_back(e);
  endtask

  // called at a falling edge; inputs are held for one cycle
  task automatic step(input logic rq, input logic dn, input logic bw, input logic bs);
    ap_work_req = rq; ap_work_done = dn; bb_wake = bw; bb_sleep = bs;
    @(negedge clk);
    ap_work_req = 0; ap_work_done = 0; bb_wake = 0; bb_sleep = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected changes and compares as the outputs move
  always @(negedge clk) begin
    if (mon_en) begin
      chk(aio_clk_en && aio_pwr_on, "R9", "audio domain on", {aio_clk_en, aio_pwr_on}, 3);
      while (expq.size() > 0 && expq[0].cyc < cyc) begin
        chk(0, expq[0].req, "missed change at cycle", cyc, expq[0].cyc);
        void'(expq.pop_front());
      end
      if ({ap_clk_en, ap_vdd_high, pwr_state} != prev) begin
        if (expq.size() == 0) begin
          chk(0, "R7", "unexpected output change", {ap_clk_en, ap_vdd_high, pwr_state}, prev);
        end else begin
          ev_t e;
          e = expq.pop_front();
          chk(e.cyc == cyc, e.req, "change cycle", cyc, e.cyc);
          chk({ap_clk_en, ap_vdd_high, pwr_state} == {e.ce, e.vd, e.cd}, e.req, "outputs",
              {ap_clk_en, ap_vdd_high, pwr_state}, {e.ce, e.vd, e.cd});
        end
      end
      // R6: invariant seen at the ports
      chk(!(ap_clk_en && !ap_vdd_high), "R6", "clock on with low supply", ap_clk_en, 0);
      prev = {ap_clk_en, ap_vdd_high, pwr_state};
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R1", "watchdog expired", cyc, 20000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c;
    idle(3);
    chk(aio_clk_en && aio_pwr_on, "R9", "audio on in reset", {aio_clk_en, aio_pwr_on}, 3);
    rst_n = 1'b1;
    idle(1);
    chk({ap_clk_en, ap_vdd_high, pwr_state} == 4'b1111, "R1", "reset state",
        {ap_clk_en, ap_vdd_high, pwr_state}, 15);
    prev = 4'b1111;
    mon_en = 1'b1;

    // R2/R3: sleep entry with settle 3
    c = cyc; push(c+1, 0, 1, {eb, 1'b0}, "R2"); push(c+5, 0, 0, {eb, 1'b0}, "R3");
    step(0, 1, 0, 0); idle(8);
    // R4: wake with ramp 4
    c = cyc; push(c+1, 0, 1, {eb, 1'b0}, "R4"); push(c+6, 1, 1, {eb, 1'b1}, "R4");
    step(1, 0, 0, 0); idle(8);
    // R7: request and done together while running
    step(1, 1, 0, 0); idle(6);
    // R5: abort right after gating
    c = cyc; push(c+1, 0, 1, {eb, 1'b0}, "R2"); push(c+2, 1, 1, {eb, 1'b1}, "R5");
    step(0, 1, 0, 0); step(1, 0, 0, 0); idle(6);
    // R5: abort in the last settle cycle
    c = cyc; push(c+1, 0, 1, {eb, 1'b0}, "R2"); push(c+5, 1, 1, {eb, 1'b1}, "R5");
    step(0, 1, 0, 0); idle(3); step(1, 0, 0, 0); idle(6);
    // R7: inputs during ramp ignored
    c = cyc; push(c+1, 0, 1, {eb, 1'b0}, "R2"); push(c+5, 0, 0, {eb, 1'b0}, "R3");
    step(0, 1, 0, 0); idle(6);
    c = cyc; push(c+1, 0, 1, {eb, 1'b0}, "R4"); push(c+6, 1, 1, {eb, 1'b1}, "R7");
    step(1, 0, 0, 0); step(0, 1, 0, 0); step(1, 0, 0, 0); idle(8);
    // R8: baseband sleeps during the settle window, AP timing unchanged
    c = cyc; push(c+1, 0, 1, 2'b10, "R2"); push(c+2, 0, 1, 2'b00, "R8");
    push(c+5, 0, 0, 2'b00, "R8");
    eb = 1'b0;
    step(0, 1, 0, 0); step(0, 0, 0, 1); idle(6);
    c = cyc; push(c+1, 0, 1, 2'b00, "R4"); push(c+6, 1, 1, 2'b01, "R4");
    step(1, 0, 0, 0); idle(8);
    // R8: wake beats sleep, then plain sleep and wake
    c = cyc; push(c+1, 1, 1, 2'b11, "R8"); eb = 1'b1;
    step(0, 0, 1, 1); idle(3);
    c = cyc; push(c+1, 1, 1, 2'b01, "R8");
    step(0, 0, 0, 1); idle(3);
    c = cyc; push(c+1, 1, 1, 2'b11, "R8");
    step(0, 0, 1, 0); idle(3);
    // R10: zero-length windows
    cfg_settle = 8'd0; cfg_ramp = 8'd0; idle(1);
    c = cyc; push(c+1, 0, 1, 2'b10, "R2"); push(c+2, 0, 0, 2'b10, "R10");
    step(0, 1, 0, 0); idle(4);
    c = cyc; push(c+1, 0, 1, 2'b10, "R10"); push(c+2, 1, 1, 2'b11, "R10");
    step(1, 0, 0, 0); idle(4);

    idle(4);
    chk(expq.size() == 0, "R3", "pending expected changes", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule